// File: doc/BRIEF.md
# Sector Erase Collection, Sequencing and Suspend Controller

This controller gathers sector-erase requests for a sectored non-volatile array, holds them in a retriggerable collection window and then erases every gathered sector in turn. Each sector goes through three steps: it is first written to all zeros, then erased, then verified. Cell physics is not modelled. The controller drives an abstract per-sector engine through a start pulse, an operation code and a sector index. The engine answers with a done pulse or a fail pulse.

Every sector-erase write made while the window is open adds its sector and restarts the window. Any other command made while the window is open cancels the whole request. A suspend made while the window is open ends the window at once and parks the controller. A suspend made during the erase run holds the engine and raises the suspended flag after a fixed latency. Resume continues the erase from where it stopped. While the controller is suspended, sectors outside the erase set can be read or programmed. Protected sectors are never added to the erase set. An engine failure parks the controller in a failed, busy state until a reset command arrives.

Top module: `sect_erase_ctrl`

## Requirements
- R1: After reset the controller is idle: `busy_o`, `win_open_o`, `suspended_o`, `fail_o`, `eng_start_o` and `eng_hold_o` are 0, `erase_mask_o` is 0 and `acc_ok_o` is 1.
- R2: A sector-erase write in idle opens the window. Each sector-erase write made while the window is open adds its unprotected sector to `erase_mask_o` (bit i is sector i). The window closes WIN_CYC cycles after the last sector-erase write.
- R3: While the window is open, a `cmd_other_i` or `cmd_reset_i` pulse without a suspend or an erase write cancels the request. On the next cycle `busy_o` is 0 and `erase_mask_o` is 0, and the engine is never started.
- R4: When the window closes with a non-empty set, the sectors are processed in ascending index order. Each sector gets three `eng_start_o` pulses, with `eng_op_o` equal to 0 (zero-fill), then 1 (erase), then 2 (verify). Each step waits for the `eng_done_i` of the step before it. A sector's mask bit clears when its verify completes, and `busy_o` drops one cycle after the last verify completes.
- R5: A suspend made while the window is open ends the window. On the next cycle `suspended_o` is 1, `win_open_o` is 0 and the mask is kept. The next resume starts the erase run.
- R6: A suspend made during the run raises `eng_hold_o` on the next cycle. `suspended_o` rises SUSP_LAT cycles after the suspend write.
- R7: While the controller is suspended, sector-erase, other, reset and repeated suspend commands leave `suspended_o` and `erase_mask_o` unchanged. A resume ends the suspension, and on the next cycle `eng_hold_o` is 0.
- R8: `acc_ok_o` is 1 in idle. While the controller is suspended, `acc_ok_o` is 1 only when `acc_sect_i` is outside `erase_mask_o`. In every other state it is 0.
- R9: A repeated resume while the run is going has no effect. Several suspend/resume rounds within one erase still complete the full step sequence.
- R10: Sectors set in `prot_mask_i` are never added. If the window closes with an empty set, `busy_o` stays 1 for PROT_CYC more cycles without any engine start and then returns to idle.
- R11: `eng_fail_i` during a step sets `fail_o` and keeps `busy_o` at 1 until `cmd_reset_i`. Only `cmd_reset_i` returns the controller to idle with the mask cleared.
- R12: During the run, sector-erase and other commands are ignored: the mask is unchanged and the window stays closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_erase_i | input | 1 | Sector-erase write pulse |
| erase_sect_i | input | SW | Sector addressed by the sector-erase write |
| cmd_suspend_i | input | 1 | Suspend command pulse |
| cmd_resume_i | input | 1 | Resume command pulse |
| cmd_reset_i | input | 1 | Reset/read command pulse |
| cmd_other_i | input | 1 | Any other command pulse |
| prot_mask_i | input | NUM_SECT | Protected sectors |
| acc_sect_i | input | SW | Sector of a read or program access being checked |
| eng_done_i | input | 1 | Engine step finished |
| eng_fail_i | input | 1 | Engine step exceeded its time limit |
| eng_start_o | output | 1 | Start the engine step |
| eng_op_o | output | 2 | Step code: 0 zero-fill, 1 erase, 2 verify |
| eng_sect_o | output | SW | Sector of the step |
| eng_hold_o | output | 1 | Engine hold request (suspending or suspended) |
| erase_mask_o | output | NUM_SECT | Sectors still to be erased |
| win_open_o | output | 1 | Collection window is open |
| suspended_o | output | 1 | Erase is suspended |
| busy_o | output | 1 | Controller is not idle |
| fail_o | output | 1 | An engine step failed |
| acc_ok_o | output | 1 | Access to `acc_sect_i` is allowed |

## Verification
Every command is a one-cycle pulse, and the state it causes is visible on the cycle after the capturing edge. The bench applies each pulse on a falling edge and samples on the next falling edge. For the window, the bench counts the falling edges on which `win_open_o` is high after the last erase write and expects exactly WIN_CYC. It counts the PROT_CYC busy cycles of an all-protected request in the same way, and the SUSP_LAT cycles from a suspend to `suspended_o`. The bench engine answers each start pulse a fixed number of cycles later. The next start is therefore due on the cycle after the done pulse, and `busy_o` falls one cycle after the final verify.

// File: rtl/sect_erase_pkg.sv
`timescale 1ns/1ps
package sect_erase_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WIN, ST_RUN, ST_SWAIT, ST_SUSP, ST_PBUSY, ST_FAIL
  } se_state_t;

  typedef enum logic [1:0] {
    OP_ZFILL = 2'd0, OP_ERASE = 2'd1, OP_VERIFY = 2'd2
  } se_op_t;
endpackage

// File: rtl/se_cyc_timer.sv
`timescale 1ns/1ps
// Cycle counter: clears on clr, counts while en, flags the LIMIT-th cycle.
module se_cyc_timer #(
  parameter int LIMIT = 16,
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign hit = (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)             cnt_d = '0;
    else if (en && !hit) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/se_low_pick.sv
`timescale 1ns/1ps
// Lowest set bit finder built from a prefix chain.
module se_low_pick #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx,
  output logic         any
);
  logic [N:0]   seen;
  logic [N-1:0] first;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_chain
    assign seen[g+1] = seen[g] | vec[g];
    assign first[g]  = vec[g] & ~seen[g];
  end

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (first[i]) idx = idx | W'(i);
  end
endmodule

// File: rtl/sect_erase_ctrl.sv
`timescale 1ns/1ps
module sect_erase_ctrl
  import sect_erase_pkg::*;
#(
  parameter int NUM_SECT = 8,
  parameter int WIN_CYC  = 6,
  parameter int SUSP_LAT = 3,
  parameter int PROT_CYC = 4,
  localparam int SW = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_erase_i,
  input  logic [SW-1:0]       erase_sect_i,
  input  logic                cmd_suspend_i,
  input  logic                cmd_resume_i,
  input  logic                cmd_reset_i,
  input  logic                cmd_other_i,
  input  logic [NUM_SECT-1:0] prot_mask_i,
  input  logic [SW-1:0]       acc_sect_i,
  input  logic                eng_done_i,
  input  logic                eng_fail_i,
  output logic                eng_start_o,
  output logic [1:0]          eng_op_o,
  output logic [SW-1:0]       eng_sect_o,
  output logic                eng_hold_o,
  output logic [NUM_SECT-1:0] erase_mask_o,
  output logic                win_open_o,
  output logic                suspended_o,
  output logic                busy_o,
  output logic                fail_o,
  output logic                acc_ok_o
);
  se_state_t           state_q, state_d;
  se_op_t              phase_q, phase_d;
  logic                act_q, act_d;
  logic [NUM_SECT-1:0] mask_q, mask_d;
  logic [NUM_SECT-1:0] new_bit;
  logic                win_hit, lat_hit, pb_hit;
  logic [SW-1:0]       cur_idx;
  logic                cur_any;

  assign new_bit = (NUM_SECT'(1) << erase_sect_i) & ~prot_mask_i;

  se_cyc_timer #(.LIMIT(WIN_CYC)) u_win_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr((state_q != ST_WIN) || cmd_erase_i),
    .en(state_q == ST_WIN), .hit(win_hit));

  se_cyc_timer #(.LIMIT(SUSP_LAT)) u_lat_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr(state_q != ST_SWAIT), .en(1'b1), .hit(lat_hit));

  se_cyc_timer #(.LIMIT(PROT_CYC)) u_pb_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr(state_q != ST_PBUSY), .en(1'b1), .hit(pb_hit));

  se_low_pick #(.N(NUM_SECT)) u_pick (
    .vec(mask_q), .idx(cur_idx), .any(cur_any));

  // Next-state process
  always_comb begin
    state_d     = state_q;
    phase_d     = phase_q;
    act_d       = act_q;
    mask_d      = mask_q;
    eng_start_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_erase_i) begin
          state_d = ST_WIN;
          mask_d  = new_bit;
        end
      end
      ST_WIN: begin
        if (cmd_suspend_i)                   state_d = ST_SUSP;
        else if (cmd_erase_i)                mask_d  = mask_q | new_bit;
        else if (cmd_other_i || cmd_reset_i) begin
          state_d = ST_IDLE;
          mask_d  = '0;
        end else if (win_hit)
          state_d = (mask_q == '0) ? ST_PBUSY : ST_RUN;
      end
      ST_RUN, ST_SWAIT: begin
        if (act_q && eng_fail_i) begin
          state_d = ST_FAIL;
        end else begin
          if (act_q && eng_done_i) begin
            act_d = 1'b0;
            if (phase_q == OP_VERIFY) begin
              mask_d  = mask_q & ~(NUM_SECT'(1) << cur_idx);
              phase_d = OP_ZFILL;
            end else begin
              phase_d = se_op_t'(phase_q + 2'd1);
            end
          end
          if (state_q == ST_RUN) begin
            if (!act_q && !cur_any) state_d = ST_IDLE;
            else if (cmd_suspend_i) state_d = ST_SWAIT;
            else if (!act_q) begin
              eng_start_o = 1'b1;
              act_d       = 1'b1;
            end
          end else if (lat_hit) begin
            state_d = ST_SUSP;
          end
        end
      end
      ST_SUSP: begin
        if (cmd_resume_i) state_d = ST_RUN;
      end
      ST_PBUSY: begin
        if (pb_hit) state_d = ST_IDLE;
      end
      ST_FAIL: begin
        if (cmd_reset_i) begin
          state_d = ST_IDLE;
          mask_d  = '0;
          act_d   = 1'b0;
          phase_d = OP_ZFILL;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= OP_ZFILL;
      act_q   <= 1'b0;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      act_q   <= act_d;
      mask_q  <= mask_d;
    end
  end

  assign eng_op_o     = phase_q;
  assign eng_sect_o   = cur_idx;
  assign eng_hold_o   = (state_q == ST_SWAIT) || (state_q == ST_SUSP);
  assign erase_mask_o = mask_q;
  assign win_open_o   = (state_q == ST_WIN);
  assign suspended_o  = (state_q == ST_SUSP);
  assign busy_o       = (state_q != ST_IDLE);
  assign fail_o       = (state_q == ST_FAIL);
  assign acc_ok_o     = (state_q == ST_IDLE) ||
                        ((state_q == ST_SUSP) && !mask_q[acc_sect_i]);

  // Assertions
  p_win_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open_o && cmd_erase_i && !cmd_suspend_i) |=> win_open_o);

  p_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open_o && !cmd_suspend_i && !cmd_erase_i && (cmd_other_i || cmd_reset_i))
    |=> (!busy_o && erase_mask_o == '0));

  p_mask_shrink_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=> ((erase_mask_o & ~$past(erase_mask_o)) == '0));

  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |-> (busy_o && !eng_hold_o && !win_open_o));

  p_susp_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open_o && cmd_suspend_i) |=> suspended_o);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    suspended_o |-> eng_hold_o);

  p_susp_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended_o && !cmd_resume_i) |=> (suspended_o && $stable(erase_mask_o)));

  p_fail_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !cmd_reset_i) |=> (fail_o && busy_o));
endmodule

// File: tb/sect_erase_ctrl_tb_top.sv
`timescale 1ns/1ps
module sect_erase_ctrl_tb_top;
  localparam int NS   = 8;
  localparam int WIN  = 6;
  localparam int LAT  = 3;
  localparam int PB   = 4;
  localparam int ELAT = 2;
  localparam int SW   = 3;
  localparam logic [NS-1:0] PROT = 8'b0010_0100;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_erase, cmd_suspend, cmd_resume, cmd_reset, cmd_other;
  logic [SW-1:0] erase_sect, acc_sect;
  logic [NS-1:0] prot_mask;
  logic eng_done, eng_fail;
  logic eng_start, eng_hold, win_open, suspended, busy, fail, acc_ok;
  logic [1:0] eng_op;
  logic [SW-1:0] eng_sect;
  logic [NS-1:0] erase_mask;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  sect_erase_ctrl #(.NUM_SECT(NS), .WIN_CYC(WIN), .SUSP_LAT(LAT), .PROT_CYC(PB)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_erase_i(cmd_erase), .erase_sect_i(erase_sect),
    .cmd_suspend_i(cmd_suspend), .cmd_resume_i(cmd_resume),
    .cmd_reset_i(cmd_reset), .cmd_other_i(cmd_other),
    .prot_mask_i(prot_mask), .acc_sect_i(acc_sect),
    .eng_done_i(eng_done), .eng_fail_i(eng_fail),
    .eng_start_o(eng_start), .eng_op_o(eng_op), .eng_sect_o(eng_sect),
    .eng_hold_o(eng_hold), .erase_mask_o(erase_mask),
    .win_open_o(win_open), .suspended_o(suspended), .busy_o(busy),
    .fail_o(fail), .acc_ok_o(acc_ok));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // Commands: 0 erase, 1 suspend, 2 resume, 3 reset, 4 other, 5 fail
  task automatic pulse(input int which, input int sect);
    erase_sect = SW'(sect);
    case (which)
      0: cmd_erase   = 1'b1;
      1: cmd_suspend = 1'b1;
      2: cmd_resume  = 1'b1;
      3: cmd_reset   = 1'b1;
      4: cmd_other   = 1'b1;
      default: eng_fail = 1'b1;
    endcase
    @(negedge clk);
    cmd_erase = 0; cmd_suspend = 0; cmd_resume = 0;
    cmd_reset = 0; cmd_other = 0; eng_fail = 0;
  endtask

  task automatic wait_start(input string req);
    int g = 0;
    while (!eng_start && g < 100) begin @(negedge clk); g++; end
    chk(eng_start, req, int'(eng_start), 1);
  endtask

  task automatic give_done();
    for (int i = 0; i < ELAT; i++) @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  // Expected step list derived from the effective erase set (R4)
  task automatic run_engine(input logic [NS-1:0] eff, input int k0);
    int es[24]; int eo[24]; int n = 0; int k; int g = 0;
    logic [NS-1:0] rem = eff;
    for (int s = 0; s < NS; s++)
      if (eff[s]) for (int o = 0; o < 3; o++) begin es[n] = s; eo[n] = o; n++; end
    if (k0 > 0) give_done();
    k = k0;
    while (busy && g < 600) begin
      if (eng_start) begin
        chk(k < n, "R4 step count", k, n);
        if (k < n) begin
          chk(int'(eng_sect) == es[k], "R4 sector order", int'(eng_sect), es[k]);
          chk(int'(eng_op) == eo[k], "R4 step code", int'(eng_op), eo[k]);
          chk(erase_mask == rem, "R4 remaining mask", int'(erase_mask), int'(rem));
          give_done();
          if (eo[k] == 2) rem[es[k]] = 1'b0;
        end else give_done();
        k++;
      end else @(negedge clk);
      g++;
    end
    chk(k == n, "R4 total steps", k, n);
    chk(!busy && erase_mask == 0, "R4 idle after run", int'(busy), 0);
  endtask

  initial begin
    logic [NS-1:0] eff;
    int n;
    bit seen;
    rst_n = 0; cmd_erase = 0; cmd_suspend = 0; cmd_resume = 0; cmd_reset = 0;
    cmd_other = 0; erase_sect = 0; acc_sect = 0; prot_mask = PROT;
    eng_done = 0; eng_fail = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(!busy && !win_open && !suspended && !fail && !eng_start && !eng_hold,
        "R1 flags", int'(busy), 0);
    chk(erase_mask == 0 && acc_ok, "R1 mask/acc", int'(erase_mask), 0);

    // Sweep over every request set, written in descending order (R2 R4 R10)
    for (int m = 1; m < 256; m++) begin
      for (int s = NS - 1; s >= 0; s--) if (m[s]) pulse(0, s);
      eff = NS'(m) & ~PROT;
      chk(win_open && erase_mask == eff, "R2 collected mask", int'(erase_mask), int'(eff));
      n = 0;
      while (win_open && n < 50) begin n++; @(negedge clk); end
      chk(n == WIN, "R2 window length", n, WIN);
      if (eff == 0) begin
        n = 0; seen = 0;
        while (busy && n < 50) begin n++; seen |= eng_start; @(negedge clk); end
        chk(n == PB && !seen, "R10 all-protected busy", n, PB);
      end else begin
        chk(!acc_ok, "R8 no access while running", int'(acc_ok), 0);
        run_engine(eff, 0);
      end
    end

    // R3 cancel by other command and by reset
    pulse(0, 0); pulse(0, 1); pulse(4, 0);
    chk(!busy && erase_mask == 0, "R3 cancel by other", int'(busy), 0);
    pulse(0, 3); pulse(3, 0);
    chk(!busy && erase_mask == 0, "R3 cancel by reset", int'(busy), 0);
    repeat (WIN + 2) @(negedge clk);
    chk(!eng_start && !busy, "R3 no engine after cancel", int'(eng_start), 0);

    // R5 suspend in window
    pulse(0, 6); pulse(1, 0);
    chk(suspended && !win_open && erase_mask == 8'h40, "R5 suspend in window",
        int'(suspended), 1);
    repeat (WIN + 2) @(negedge clk);
    chk(suspended && !eng_start, "R5 stays suspended", int'(suspended), 1);
    pulse(2, 0);
    chk(eng_start && eng_sect == 6 && eng_op == 0, "R5 resume starts run",
        int'(eng_start), 1);
    run_engine(8'h40, 0);

    // R6 R7 R8 R9 R12 suspend during run
    pulse(0, 3); pulse(0, 1);
    wait_start("R4 first start");
    chk(eng_sect == 1 && eng_op == 0, "R4 first step", int'(eng_sect), 1);
    @(negedge clk);
    pulse(0, 4); pulse(4, 0);
    chk(erase_mask == 8'h0A && !win_open, "R12 run ignores commands",
        int'(erase_mask), 8'h0A);
    pulse(2, 0);
    chk(!suspended && !eng_hold && busy, "R9 redundant resume", int'(eng_hold), 0);
    pulse(1, 0);
    chk(eng_hold && !suspended, "R6 hold next cycle", int'(eng_hold), 1);
    n = 1;
    while (!suspended && n < 50) begin n++; @(negedge clk); end
    chk(n == LAT + 1, "R6 suspend latency", n - 1, LAT);
    acc_sect = 1; #1;
    chk(!acc_ok, "R8 erasing sector blocked", int'(acc_ok), 0);
    acc_sect = 3; #1;
    chk(!acc_ok, "R8 erasing sector blocked", int'(acc_ok), 0);
    acc_sect = 4; #1;
    chk(acc_ok, "R8 other sector allowed", int'(acc_ok), 1);
    pulse(0, 4); pulse(4, 0); pulse(1, 0); pulse(3, 0);
    chk(suspended && erase_mask == 8'h0A, "R7 commands ignored while suspended",
        int'(erase_mask), 8'h0A);
    pulse(2, 0);
    chk(!suspended && !eng_hold, "R7 resume releases hold", int'(eng_hold), 0);
    pulse(1, 0); pulse(1, 0);
    repeat (LAT) @(negedge clk);
    chk(suspended, "R9 second suspend round", int'(suspended), 1);
    pulse(2, 0); pulse(2, 0);
    chk(!suspended && !eng_start, "R9 no restart of running step", int'(eng_start), 0);
    run_engine(8'h0A, 1);

    // R11 fail
    pulse(0, 0);
    wait_start("R11 start");
    @(negedge clk);
    pulse(5, 0);
    chk(fail && busy, "R11 fail set", int'(fail), 1);
    pulse(4, 0); pulse(2, 0);
    repeat (3) @(negedge clk);
    chk(fail && busy, "R11 fail held", int'(fail), 1);
    pulse(3, 0);
    chk(!fail && !busy && erase_mask == 0, "R11 reset clears", int'(fail), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule